// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block walks a circular ring of receive buffer descriptors in memory for a receive DMA engine. When the receive data path signals that a frame is starting, the block fetches the descriptor under its queue pointer through a simple word-wide memory request port. It checks the ownership flag and hands the buffer address to the data mover. When the buffer has been filled, it writes the descriptor's first word back with ownership set and moves the pointer on. A wrap flag in a descriptor sends the pointer back to the ring base.

The descriptor size follows the configuration. Two words form the basic entry. In extended mode, a 64-bit address option adds two words, and so does a timestamp option. The upper address half comes from the third word when 64-bit addressing is on. A data-path error drops the current buffer without write-back, so the same descriptor is offered again. A descriptor that software still owns raises a buffer-not-available status and a one-cycle interrupt, and it increments a resource error counter. The frame is then either dropped at once or held back, depending on the discard option. Each later frame start fetches the same descriptor again.

Top module: `rxd_ring_mgr`

## Requirements
- R1: After a buffer is committed, the queue pointer advances by 4 bytes times the descriptor size. The size is 2 words, plus 2 when extended mode and 64-bit addressing are both set, plus 2 when extended mode and timestamp mode are both set.
- R2: A descriptor is usable only when bit 0 of word 0 reads 0. On `frm_end` the block writes word 0 back with bit 0 set and all other bits unchanged.
- R3: When the committed descriptor has bit 1 of word 0 (wrap) set, the queue pointer reloads the base address instead of advancing.
- R4: A base address write loads both the base and the queue pointer, with bits 1:0 cleared, only while `cfg_rx_en` is 0. While receive is enabled the write is ignored. `cfg_qptr` always shows the queue pointer.
- R5: Fetching a descriptor whose ownership bit is 1 sets `nobuf`, pulses `irq` for one cycle and increments `res_err_cnt` by one, saturating.
- R6: With `cfg_drop` at 0, no buffer is offered after a used descriptor. Each later `frm_start` fetches the same descriptor again, and a fetch that finds it free offers it.
- R7: With `cfg_drop` at 1, a frame that finds a used descriptor is discarded with a one-cycle `frm_drop` pulse. The pointer stays in place.
- R8: `frm_err` while a buffer is offered abandons it. No write-back takes place, the pointer does not move, and the next frame is offered the same buffer.
- R9: `buf_addr` is {upper, word 0 bits 31:2, 00} plus the byte offset. Upper is word 2 when extended mode and 64-bit addressing are both set, and zero otherwise.
- R10: `buf_room` equals BUF_BYTES minus `cfg_ofs` (0 to 3 bytes).
- R11: After reset the queue pointer, base, counter, `nobuf`, `irq`, `buf_valid` and `mem_req` are all 0.
- R12: `nobuf` clears when a fetched descriptor is found free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_ext | input | 1 | Extended descriptor mode |
| cfg_a64 | input | 1 | 64-bit buffer addressing |
| cfg_ts | input | 1 | Timestamp words present |
| cfg_drop | input | 1 | Discard a frame when no buffer is free |
| cfg_ofs | input | 2 | Byte offset of the buffer start |
| cfg_base_we | input | 1 | Base address write strobe |
| cfg_base_wdata | input | AW | Base address write data |
| cfg_qptr | output | AW | Current queue pointer |
| frm_start | input | 1 | A new frame needs a buffer |
| frm_end | input | 1 | Offered buffer is filled; commit it |
| frm_err | input | 1 | Receive error; recover the offered buffer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Request completed |
| buf_valid | output | 1 | Buffer offered to the data mover |
| buf_addr | output | 64 | Offered buffer byte address |
| buf_room | output | LEN_W | Usable bytes in the offered buffer |
| frm_drop | output | 1 | Frame discarded, no buffer |
| nobuf | output | 1 | Buffer-not-available status |
| irq | output | 1 | Buffer-not-available interrupt pulse |
| res_err_cnt | output | CNT_W | Resource error count |

## Verification
The bench builds the block with its defaults: a 32-bit pointer, 128-byte buffers, an 8-bit counter and 64-bit support enabled. It then sweeps five descriptor layouts: basic, 64-bit, timestamp, both, and extension bits ignored with extended mode off. A three-entry ring makes every layout wrap, covers every byte offset, and shows the stride through the pointer read-back. With 64-bit support built in, the upper-address word path and its suppression are both reachable. Separate runs cover error recovery, hold-and-refetch and discard on used descriptors.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_RD0,
      S_RD2,
      S_OFFER,
      S_WB,
      S_WAIT
   } rxd_state_e;

   function automatic logic [4:0] desc_bytes(input logic ext, input logic a64, input logic ts);
      logic [4:0] n;
      n = 5'd8;
      if (ext && a64) n = n + 5'd8;
      if (ext && ts)  n = n + 5'd8;
      return n;
   endfunction
endpackage

// File: rtl/rxd_qptr.sv
module rxd_qptr #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_en,
   input  logic          base_we,
   input  logic [AW-1:0] base_wdata,
   input  logic          adv,
   input  logic          adv_wrap,
   input  logic [4:0]    step,
   output logic [AW-1:0] qptr,
   output logic [AW-1:0] base
);
   localparam logic [AW-1:0] ALIGN_MASK = ~{{(AW-2){1'b0}}, 2'b11};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base <= '0;
         qptr <= '0;
      end else if (base_we && !rx_en) begin
         base <= base_wdata & ALIGN_MASK;
         qptr <= base_wdata & ALIGN_MASK;
      end else if (adv) begin
         qptr <= adv_wrap ? base : qptr + AW'(step);
      end
   end
endmodule

// File: rtl/rxd_errcnt.sv
module rxd_errcnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CMAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (inc && cnt != CMAX) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rxd_fsm.sv
module rxd_fsm
   import rxd_pkg::*;
#(
   parameter int AW         = 32,
   parameter int BUF_BYTES  = 128,
   parameter int LEN_W      = 14,
   parameter bit SUPPORT_64 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             cfg_ext,
   input  logic             cfg_a64,
   input  logic             cfg_drop,
   input  logic [1:0]       cfg_ofs,
   input  logic             frm_start,
   input  logic             frm_end,
   input  logic             frm_err,
   input  logic [AW-1:0]    qptr,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   input  logic             mem_ack,
   output logic             buf_valid,
   output logic [63:0]      buf_addr,
   output logic [LEN_W-1:0] buf_room,
   output logic             frm_drop,
   output logic             nobuf,
   output logic             irq,
   output logic             adv,
   output logic             adv_wrap
);
   localparam logic [AW-1:0]    HI_OFS = AW'(8);
   localparam logic [LEN_W-1:0] ROOM   = LEN_W'(BUF_BYTES);

   rxd_state_e  state;
   logic [31:0] w0_q;
   logic [31:0] hi_q;
   logic        use_hi;

   generate
      if (SUPPORT_64) begin : g_hi
         assign use_hi = cfg_ext & cfg_a64;
      end else begin : g_nohi
         assign use_hi = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         w0_q     <= '0;
         hi_q     <= '0;
         nobuf    <= 1'b0;
         irq      <= 1'b0;
         frm_drop <= 1'b0;
      end else begin
         irq      <= 1'b0;
         frm_drop <= 1'b0;
         unique case (state)
            S_IDLE, S_WAIT: if (rx_en && frm_start) state <= S_RD0;
            S_RD0: if (mem_ack) begin
               w0_q <= mem_rdata;
               if (mem_rdata[0]) begin
                  nobuf <= 1'b1;
                  irq   <= 1'b1;
                  if (cfg_drop) begin
                     frm_drop <= 1'b1;
                     state    <= S_IDLE;
                  end else begin
                     state <= S_WAIT;
                  end
               end else begin
                  nobuf <= 1'b0;
                  hi_q  <= '0;
                  state <= use_hi ? S_RD2 : S_OFFER;
               end
            end
            S_RD2: if (mem_ack) begin
               hi_q  <= mem_rdata;
               state <= S_OFFER;
            end
            S_OFFER: begin
               if (frm_err)      state <= S_IDLE;
               else if (frm_end) state <= S_WB;
            end
            S_WB: if (mem_ack) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (state == S_RD0) || (state == S_RD2) || (state == S_WB);
      mem_we    = (state == S_WB);
      mem_addr  = (state == S_RD2) ? qptr + HI_OFS : qptr;
      mem_wdata = w0_q | 32'h1;
      buf_valid = (state == S_OFFER);
      buf_addr  = {hi_q, w0_q[31:2], 2'b00} + {62'd0, cfg_ofs};
      buf_room  = ROOM - LEN_W'(cfg_ofs);
      adv       = (state == S_WB) && mem_ack;
      adv_wrap  = w0_q[1];
   end
endmodule

// File: rtl/rxd_ring_mgr.sv
module rxd_ring_mgr
   import rxd_pkg::*;
#(
   parameter int AW         = 32,
   parameter int BUF_BYTES  = 128,
   parameter int LEN_W      = 14,
   parameter int CNT_W      = 8,
   parameter bit SUPPORT_64 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_rx_en,
   input  logic             cfg_ext,
   input  logic             cfg_a64,
   input  logic             cfg_ts,
   input  logic             cfg_drop,
   input  logic [1:0]       cfg_ofs,
   input  logic             cfg_base_we,
   input  logic [AW-1:0]    cfg_base_wdata,
   output logic [AW-1:0]    cfg_qptr,
   input  logic             frm_start,
   input  logic             frm_end,
   input  logic             frm_err,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   input  logic             mem_ack,
   output logic             buf_valid,
   output logic [63:0]      buf_addr,
   output logic [LEN_W-1:0] buf_room,
   output logic             frm_drop,
   output logic             nobuf,
   output logic             irq,
   output logic [CNT_W-1:0] res_err_cnt
);
   generate
      if (AW < 8 || AW > 64) begin : g_bad_aw
         $error("rxd_ring_mgr: AW out of range");
      end
      if (BUF_BYTES < 8 || LEN_W < $clog2(BUF_BYTES + 1)) begin : g_bad_len
         $error("rxd_ring_mgr: LEN_W too small for BUF_BYTES");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("rxd_ring_mgr: CNT_W must be positive");
      end
   endgenerate

   logic          adv, adv_wrap;
   logic [4:0]    step;
   logic [AW-1:0] base;

   assign step = desc_bytes(cfg_ext, cfg_a64 & SUPPORT_64, cfg_ts);

   rxd_qptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .rx_en(cfg_rx_en),
      .base_we(cfg_base_we), .base_wdata(cfg_base_wdata),
      .adv(adv), .adv_wrap(adv_wrap), .step(step),
      .qptr(cfg_qptr), .base(base)
   );

   rxd_fsm #(.AW(AW), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .SUPPORT_64(SUPPORT_64)) u_fsm (
      .clk(clk), .rst_n(rst_n), .rx_en(cfg_rx_en),
      .cfg_ext(cfg_ext), .cfg_a64(cfg_a64), .cfg_drop(cfg_drop), .cfg_ofs(cfg_ofs),
      .frm_start(frm_start), .frm_end(frm_end), .frm_err(frm_err),
      .qptr(cfg_qptr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_room(buf_room),
      .frm_drop(frm_drop), .nobuf(nobuf), .irq(irq),
      .adv(adv), .adv_wrap(adv_wrap)
   );

   rxd_errcnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(irq), .cnt(res_err_cnt)
   );
endmodule

// File: rtl/rxd_ring_mgr_sva.sv
module rxd_ring_mgr_sva #(
   parameter int AW    = 32,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_rx_en,
   input logic             cfg_base_we,
   input logic [AW-1:0]    cfg_base_wdata,
   input logic [AW-1:0]    cfg_qptr,
   input logic [AW-1:0]    base,
   input logic             frm_err,
   input logic             mem_req,
   input logic             mem_we,
   input logic [31:0]      mem_wdata,
   input logic             mem_ack,
   input logic             buf_valid,
   input logic             nobuf,
   input logic             irq,
   input logic [CNT_W-1:0] res_err_cnt
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   a_r2_wb_sets_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[0]);

   a_r3_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack && mem_wdata[1] && !cfg_base_we) |=> (cfg_qptr == base));

   a_r4_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rx_en && cfg_base_we && !(mem_req && mem_we && mem_ack)) |=> $stable(cfg_qptr));

   a_r4_base_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rx_en && cfg_base_we) |=> (cfg_qptr == {$past(cfg_base_wdata[AW-1:2]), 2'b00}));

   a_r5_irq_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> nobuf);

   a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && res_err_cnt != CMAX) |=> (res_err_cnt == $past(res_err_cnt) + 1'b1));

   a_r8_err_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_valid && frm_err) |=> !mem_req);

   a_r11_offer_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(buf_valid && mem_req));
endmodule

bind rxd_ring_mgr rxd_ring_mgr_sva #(.AW(AW), .CNT_W(CNT_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_base_we(cfg_base_we),
   .cfg_base_wdata(cfg_base_wdata), .cfg_qptr(cfg_qptr), .base(base),
   .frm_err(frm_err), .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
   .mem_ack(mem_ack), .buf_valid(buf_valid), .nobuf(nobuf), .irq(irq),
   .res_err_cnt(res_err_cnt)
);

// File: tb/tb_rxd_ring_mgr.sv
module tb_rxd_ring_mgr;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        cfg_rx_en = 0, cfg_ext = 0, cfg_a64 = 0, cfg_ts = 0, cfg_drop = 0;
   logic [1:0]  cfg_ofs = 0;
   logic        cfg_base_we = 0;
   logic [31:0] cfg_base_wdata = 0;
   logic [31:0] cfg_qptr;
   logic        frm_start = 0, frm_end = 0, frm_err = 0;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        buf_valid, frm_drop, nobuf, irq;
   logic [63:0] buf_addr;
   logic [13:0] buf_room;
   logic [7:0]  res_err_cnt;

   rxd_ring_mgr dut (.*);

   logic [31:0] mem [0:63];
   initial mem_ack = 1'b0;
   initial mem_rdata = '0;
   always @(posedge clk) begin
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= mem[mem_addr[7:2]];
      if (mem_req && mem_we && !mem_ack) mem[mem_addr[7:2]] <= mem_wdata;
   end

   int n_run = 0, n_fail = 0;
   bit irq_seen, drop_seen, got;
   localparam logic [31:0] BASE = 32'h40;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic request_buf();
      irq_seen = 0; drop_seen = 0; got = 0;
      @(negedge clk) frm_start = 1;
      @(negedge clk) frm_start = 0;
      for (int k = 0; k < 12 && !got; k++) begin
         if (buf_valid) got = 1;
         irq_seen  |= irq;
         drop_seen |= frm_drop;
         if (!got) @(negedge clk);
      end
   endtask

   task automatic commit(input bit err);
      if (err) frm_err = 1; else frm_end = 1;
      @(negedge clk);
      frm_err = 0; frm_end = 0;
      repeat (5) @(negedge clk);
   endtask

   function automatic logic [31:0] bufb(input int m, input int i);
      return 32'h1000 * (i + 1) + 32'h100 * m;
   endfunction

   task automatic build_ring(input int m, input int w, input bit hi_on);
      for (int a = 0; a < 64; a++) mem[a] = 32'hDEAD0000 + a;
      for (int i = 0; i < 3; i++) begin
         mem[16 + i*w]     = bufb(m, i) | ((i == 2) ? 32'h2 : 32'h0);
         mem[16 + i*w + 1] = 32'h0;
         if (hi_on) mem[16 + i*w + 2] = 32'hA0 + i;
      end
      @(negedge clk) cfg_rx_en = 0; cfg_base_we = 1; cfg_base_wdata = BASE;
      @(negedge clk) cfg_base_we = 0; cfg_rx_en = 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk(cfg_qptr == 0 && res_err_cnt == 0 && !nobuf && !irq && !buf_valid && !mem_req,
          "R11 reset", {cfg_qptr, 24'd0, res_err_cnt}, 64'd0);

      for (int m = 0; m < 5; m++) begin
         bit ext, a64, ts, hi_on;
         int w;
         ext = (m < 4); a64 = m[0] || m == 4; ts = m[1] || m == 4;
         hi_on = ext && a64;
         w = 2 + (hi_on ? 2 : 0) + ((ext && ts) ? 2 : 0);
         cfg_ext = ext; cfg_a64 = a64; cfg_ts = ts; cfg_ofs = 2'(m); cfg_drop = 0;
         build_ring(m, w, hi_on);
         for (int f = 0; f < 4; f++) begin
            int i;
            logic [63:0] ea;
            i = f % 3;
            if (f == 3) mem[16] = mem[16] & ~32'h1;
            request_buf();
            ea = {hi_on ? 32'hA0 + i : 32'h0, bufb(m, i)} + 64'(m % 4);
            chk(got && buf_addr == ea, "R9 buffer address", buf_addr, ea);
            chk(buf_room == 14'(128 - m % 4), "R10 room", 64'(buf_room), 64'(128 - m % 4));
            commit(0);
            chk(mem[16 + i*w] == ((bufb(m, i) | ((i == 2) ? 32'h2 : 32'h0)) | 32'h1),
                "R2 owner write-back", 64'(mem[16 + i*w]), 64'(bufb(m, i) | 1));
            if (f == 2) chk(cfg_qptr == BASE, "R3 wrap reload", 64'(cfg_qptr), 64'(BASE));
         end
         cfg_rx_en = 0;
         @(negedge clk);
         chk(cfg_qptr == BASE + 4*w, "R1 stride", 64'(cfg_qptr), 64'(BASE + 4*w));
      end

      // basic ring for the handling tests
      cfg_ext = 0; cfg_a64 = 0; cfg_ts = 0; cfg_ofs = 0; cfg_drop = 0;
      build_ring(0, 2, 0);
      @(negedge clk) cfg_base_we = 1; cfg_base_wdata = 32'h80;
      @(negedge clk) cfg_base_we = 0;
      chk(cfg_qptr == BASE, "R4 base write ignored while enabled", 64'(cfg_qptr), 64'(BASE));

      // R8 error recovery on descriptor 0
      request_buf();
      chk(got && buf_addr == 64'(bufb(0, 0)), "R8 first offer", buf_addr, 64'(bufb(0, 0)));
      commit(1);
      chk(mem[16] == bufb(0, 0) && cfg_qptr == BASE, "R8 no write-back",
          {mem[16], cfg_qptr}, {bufb(0, 0), BASE});
      request_buf();
      chk(got && buf_addr == 64'(bufb(0, 0)), "R8 same buffer again", buf_addr, 64'(bufb(0, 0)));
      commit(0);

      // R5 / R6 / R12 hold mode on descriptor 1
      mem[18] = mem[18] | 32'h1;
      request_buf();
      chk(!got && irq_seen && nobuf && res_err_cnt == 1, "R5 used descriptor",
          {got, irq_seen, nobuf, 53'd0, res_err_cnt}, {3'b011, 53'd0, 8'd1});
      request_buf();
      chk(!got && res_err_cnt == 2, "R6 refetch per frame", 64'(res_err_cnt), 64'd2);
      mem[18] = mem[18] & ~32'h1;
      request_buf();
      chk(got && buf_addr == 64'(bufb(0, 1)), "R6 freed buffer offered", buf_addr, 64'(bufb(0, 1)));
      chk(!nobuf, "R12 status clears", 64'(nobuf), 64'd0);
      commit(0);

      // R7 discard mode on descriptor 2
      cfg_drop = 1;
      mem[20] = mem[20] | 32'h1;
      request_buf();
      chk(!got && drop_seen && res_err_cnt == 3 && cfg_qptr == BASE + 16, "R7 frame dropped",
          {got, drop_seen, 54'd0, res_err_cnt}, {2'b01, 54'd0, 8'd3});
      mem[20] = mem[20] & ~32'h1;
      request_buf();
      chk(got && buf_addr == 64'(bufb(0, 2)), "R7 same descriptor next frame", buf_addr, 64'(bufb(0, 2)));
      commit(0);
      chk(cfg_qptr == BASE, "R3 wrap after discard", 64'(cfg_qptr), 64'(BASE));

      // R4 base write accepted while disabled, alignment
      @(negedge clk) cfg_rx_en = 0; cfg_base_we = 1; cfg_base_wdata = 32'h87;
      @(negedge clk) cfg_base_we = 0;
      chk(cfg_qptr == 32'h84, "R4 base load when disabled", 64'(cfg_qptr), 64'h84);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule